// File: doc/BRIEF.md
# Branch Target Buffer (direct-mapped, tagged)

This block stores the destinations of recently resolved control transfers so that the fetch stage can steer to a predicted next PC without waiting for the branch to resolve. Each entry is selected by the word-address bits just above the byte offset. The entry holds the remaining upper PC bits as a tag, the full target address and a valid flag. A lookup returns a hit flag and the stored target. Whether a conditional branch is actually taken is left to a separate direction predictor, which this buffer pairs with.

Entries are installed from two pipeline points. Direct jumps, whose target is known once the instruction is decoded, write through the decode port. Register-indirect jumps and conditional branches resolve later and write through the execute port. Storage has a single write path, so an execute write wins over a decode write in the same cycle. The tag and target sit in a read-first synchronous memory that maps onto block RAM. The valid flags sit in flops so that reset can clear them.

Top module: `btb_direct`

## Requirements
- R1: After reset no lookup hits until an entry has been written; during and after reset `lk_hit` is 0.
- R2: `lk_hit` and `lk_target` are due exactly one clock cycle after `lk_pc` is presented at a rising edge.
- R3: The entry is selected by `pc[IDX_W+1:2]`; the two lowest PC bits are ignored for both lookup and write, so PCs differing only in bits [1:0] give the same result.
- R4: A hit requires the stored tag `pc[31:IDX_W+2]` to equal the lookup PC's upper bits; a lookup on the same index with different upper bits misses.
- R5: On a hit `lk_target` carries the full 32-bit stored target; on a miss it is 0.
- R6: A decode-port write (`dec_we`=1) sets the entry valid and installs its tag and target.
- R7: An execute-port write (`exe_we`=1) sets the entry valid and installs its tag and target.
- R8: When both ports write in the same cycle, only the execute write takes effect, whether or not the indices match; the decode write is dropped.
- R9: A lookup in the same cycle as a write to the same index returns the contents from before that write.
- R10: A write to a valid entry replaces its tag and target, so the previous PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all valid flags |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Registered hit for the PC presented on the previous edge |
| lk_target | output | 32 | Registered predicted target, 0 on a miss |
| dec_we | input | 1 | Write request from decode (direct jumps) |
| dec_pc | input | 32 | PC of the decoded jump |
| dec_target | input | 32 | Target of the decoded jump |
| exe_we | input | 1 | Write request from execute (indirect jumps, branches) |
| exe_pc | input | 32 | PC of the resolved instruction |
| exe_target | input | 32 | Resolved target |

## Verification
Every lookup result is due one cycle after its PC is sampled at a rising edge. A write becomes visible to a lookup sampled at the following edge, and is invisible to a lookup sampled at the same edge. The bench's reference model works the same way. At each rising edge it first computes the expected response from its pre-write state, then applies the prioritised write. It compares the design's outputs with that expectation at the next falling edge. Directed checks cover reset, offset aliasing, tag mismatch, dual-port collisions and read-during-write, and a pseudo-random phase follows them.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int PC_W  = 32;
  localparam int OFS_W = 2;
  typedef logic [PC_W-1:0] pc_t;
endpackage

// File: rtl/btb_wr_sel.sv
module btb_wr_sel
  import btb_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic             dec_we,
  input  pc_t              dec_pc,
  input  pc_t              dec_target,
  input  logic             exe_we,
  input  pc_t              exe_pc,
  input  pc_t              exe_target,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output pc_t              wr_target
);
  pc_t sel_pc;

  always_comb begin
    wr_en = exe_we | dec_we;
    if (exe_we) begin
      sel_pc    = exe_pc;
      wr_target = exe_target;
    end else begin
      sel_pc    = dec_pc;
      wr_target = dec_target;
    end
  end

  assign wr_idx = sel_pc[IDX_W+OFS_W-1:OFS_W];
  assign wr_tag = sel_pc[PC_W-1:IDX_W+OFS_W];

  logic unused_ofs;
  assign unused_ofs = ^sel_pc[OFS_W-1:0];
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W - OFS_W,
  localparam int DEPTH = 1 << IDX_W,
  localparam int ENT_W = TAG_W + PC_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  pc_t              wr_target,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output pc_t              rd_target
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [ENT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    rd_q <= mem[rd_idx];
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_target};
  end

  assign rd_tag    = rd_q[ENT_W-1:PC_W];
  assign rd_target = rd_q[PC_W-1:0];
endmodule

// File: rtl/btb_valid.sv
module btb_valid #(
  parameter int IDX_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld
);
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= vld[rd_idx];
      if (wr_en) vld[wr_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/btb_direct.sv
module btb_direct
  import btb_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lk_pc,
  output logic        lk_hit,
  output logic [31:0] lk_target,
  input  logic        dec_we,
  input  logic [31:0] dec_pc,
  input  logic [31:0] dec_target,
  input  logic        exe_we,
  input  logic [31:0] exe_pc,
  input  logic [31:0] exe_target
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  pc_t              wr_target;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag, lk_tag_q;
  pc_t              rd_target;
  logic             rd_vld;

  assign rd_idx = lk_pc[IDX_W+OFS_W-1:OFS_W];

  btb_wr_sel #(.IDX_W(IDX_W)) u_sel (
    .dec_we(dec_we), .dec_pc(dec_pc), .dec_target(dec_target),
    .exe_we(exe_we), .exe_pc(exe_pc), .exe_target(exe_target),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_target(wr_target)
  );

  btb_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_target(wr_target), .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_target(rd_target)
  );

  btb_valid #(.IDX_W(IDX_W)) u_valid (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .rd_idx(rd_idx), .rd_vld(rd_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) lk_tag_q <= '0;
    else     lk_tag_q <= lk_pc[PC_W-1:IDX_W+OFS_W];
  end

  assign lk_hit    = rd_vld && (rd_tag == lk_tag_q);
  assign lk_target = lk_hit ? rd_target : '0;

  logic unused_ofs;
  assign unused_ofs = ^lk_pc[OFS_W-1:0];

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_hit);

  // R7
  exe_install_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(exe_we, 2) && !$past(exe_we) && !$past(dec_we)
     && $past(lk_pc[31:2]) == $past(exe_pc[31:2], 2))
    |-> (lk_hit && lk_target == $past(exe_target, 2)));

  // R6
  dec_install_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(dec_we, 2) && !$past(exe_we, 2)
     && !$past(exe_we) && !$past(dec_we) && $past(lk_pc[31:2]) == $past(dec_pc[31:2], 2))
    |-> (lk_hit && lk_target == $past(dec_target, 2)));

  // R8
  exe_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(dec_we, 2) && $past(exe_we, 2)
     && !$past(exe_we) && !$past(dec_we)
     && $past(dec_pc[IDX_W+1:2], 2) == $past(exe_pc[IDX_W+1:2], 2)
     && $past(dec_pc[31:IDX_W+2], 2) != $past(exe_pc[31:IDX_W+2], 2)
     && $past(lk_pc[31:2]) == $past(dec_pc[31:2], 2))
    |-> !lk_hit);
endmodule

// File: tb/sim_btb_direct.sv
module sim_btb_direct;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] lk_pc = '0, dec_pc = '0, dec_target = '0, exe_pc = '0, exe_target = '0;
  logic dec_we = 1'b0, exe_we = 1'b0;
  logic lk_hit;
  logic [31:0] lk_target;

  always #2.5 clk = ~clk;

  btb_direct #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .dec_we(dec_we), .dec_pc(dec_pc), .dec_target(dec_target),
    .exe_we(exe_we), .exe_pc(exe_pc), .exe_target(exe_target)
  );

  int checks = 0, errors = 0;
  string phase = "R1";

  // behavioural reference model
  bit          m_vld [DEPTH];
  logic [31:0] m_pc  [DEPTH];
  logic [31:0] m_tgt [DEPTH];
  logic        exp_hit = 1'b0;
  logic [31:0] exp_tgt = '0;
  bit          cmp_on = 1'b0;

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_vld[i]) m_vld[i] = 1'b0;
      exp_hit = 1'b0;
      exp_tgt = '0;
    end else begin
      int li;
      li = idx_of(lk_pc);
      exp_hit = m_vld[li] && (m_pc[li][31:IDX_W+2] == lk_pc[31:IDX_W+2]);
      exp_tgt = exp_hit ? m_tgt[li] : 32'h0;
      if (exe_we) begin
        m_vld[idx_of(exe_pc)] = 1'b1;
        m_pc[idx_of(exe_pc)]  = exe_pc;
        m_tgt[idx_of(exe_pc)] = exe_target;
      end else if (dec_we) begin
        m_vld[idx_of(dec_pc)] = 1'b1;
        m_pc[idx_of(dec_pc)]  = dec_pc;
        m_tgt[idx_of(dec_pc)] = dec_target;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
        errors++;
        $display("FAIL %s model: hit=%0b target=%h expected hit=%0b target=%h",
                 phase, lk_hit, lk_target, exp_hit, exp_tgt);
      end
    end
  end

  task automatic chk(string r, logic h, logic [31:0] t);
    checks++;
    if (lk_hit !== h || lk_target !== t) begin
      errors++;
      $display("FAIL %s direct: hit=%0b target=%h expected hit=%0b target=%h",
               r, lk_hit, lk_target, h, t);
    end
  endtask

  // one cycle: drive at negedge, result of this lookup visible at the next negedge
  task automatic step(logic [31:0] lpc, logic dw, logic [31:0] dp, logic [31:0] dt,
                      logic ew, logic [31:0] ep, logic [31:0] et);
    lk_pc = lpc; dec_we = dw; dec_pc = dp; dec_target = dt;
    exe_we = ew; exe_pc = ep; exe_target = et;
    @(negedge clk);
  endtask

  localparam logic [31:0] A  = 32'h0040_0010;
  localparam logic [31:0] A2 = A + (32'h1 << (IDX_W + 2));
  localparam logic [31:0] B  = 32'h0040_0020;
  localparam logic [31:0] C  = 32'h0040_0030;
  localparam logic [31:0] D  = 32'h0040_0040;
  localparam logic [31:0] E  = 32'h0040_0050;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 32'h0);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1: nothing written, all misses
    phase = "R1";
    step(A, 0, 0, 0, 0, 0, 0); chk("R1", 0, 0);
    step(B, 0, 0, 0, 0, 0, 0); chk("R1", 0, 0);
    // R7 / R2: execute write then look up next cycle
    phase = "R7";
    step(0, 0, 0, 0, 1, A, 32'h1111_0000);
    step(A, 0, 0, 0, 0, 0, 0); chk("R2", 1, 32'h1111_0000);
    // R3: byte offset ignored
    phase = "R3";
    step(A | 32'h3, 0, 0, 0, 0, 0, 0); chk("R3", 1, 32'h1111_0000);
    step(A | 32'h1, 0, 0, 0, 0, 0, 0); chk("R3", 1, 32'h1111_0000);
    // R4 / R5: same index other tag misses with zero target
    phase = "R4";
    step(A2, 0, 0, 0, 0, 0, 0); chk("R4", 0, 32'h0);
    // R6: decode write
    phase = "R6";
    step(0, 1, B | 32'h2, 32'h2222_0004, 0, 0, 0);
    step(B, 0, 0, 0, 0, 0, 0); chk("R6", 1, 32'h2222_0004);
    // R8: collision, same index different tag
    phase = "R8";
    step(0, 1, C + (32'h1 << (IDX_W + 2)), 32'hDDDD_0000, 1, C, 32'h3333_0000);
    step(C, 0, 0, 0, 0, 0, 0); chk("R8", 1, 32'h3333_0000);
    step(C + (32'h1 << (IDX_W + 2)), 0, 0, 0, 0, 0, 0); chk("R8", 0, 32'h0);
    // R8: different indices, decode dropped
    step(0, 1, D, 32'h4444_0000, 1, E, 32'h5555_0000);
    step(D, 0, 0, 0, 0, 0, 0); chk("R8", 0, 32'h0);
    step(E, 0, 0, 0, 0, 0, 0); chk("R8", 1, 32'h5555_0000);
    // R9: read during write returns old contents
    phase = "R9";
    step(D, 1, D, 32'h6666_0000, 0, 0, 0); chk("R9", 0, 32'h0);
    step(D, 0, 0, 0, 1, D, 32'h7777_0000); chk("R9", 1, 32'h6666_0000);
    step(D, 0, 0, 0, 0, 0, 0); chk("R9", 1, 32'h7777_0000);
    // R10: overwrite with other tag
    phase = "R10";
    step(0, 0, 0, 0, 1, A2, 32'h8888_0000);
    step(A, 0, 0, 0, 0, 0, 0); chk("R10", 0, 32'h0);
    step(A2, 0, 0, 0, 0, 0, 0); chk("R10", 1, 32'h8888_0000);
    // R5: pseudo-random traffic over a small PC space
    phase = "R5";
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] p0, p1, p2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p0 = (lfsr[0] ? 32'h0080_0000 : 32'h0040_0000) | {26'h0, lfsr[3:1], 3'b0} | {30'h0, lfsr[5:4]};
      p1 = (lfsr[6] ? 32'h0080_0000 : 32'h0040_0000) | {26'h0, lfsr[9:7], 3'b0};
      p2 = (lfsr[10] ? 32'h0080_0000 : 32'h0040_0000) | {26'h0, lfsr[13:11], 3'b0};
      step(p0, lfsr[14], p1, {16'hD000, lfsr}, lfsr[15], p2, {16'hE000, ~lfsr});
    end
    // R1: reset again clears everything
    phase = "R1";
    rst = 1'b1;
    cmp_on = 1'b0;
    step(E, 0, 0, 0, 0, 0, 0);
    step(E, 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
    step(E, 0, 0, 0, 0, 0, 0); chk("R1", 0, 32'h0);
    step(D, 0, 0, 0, 0, 0, 0); chk("R1", 0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule